// File: doc/BRIEF.md
# ADC Code-Transition Servo Controller

This block measures every code transition level of an analog-to-digital converter under test. A DAC word drives the converter's input through an external DAC. The controller closes a loop on the returned code. For each target code it steps the DAC word by one LSB after every accepted conversion: up when the code is below the target, down otherwise. The first downward step for a target marks the point where the loop starts to dither across the transition. From there the controller lets a fixed number of conversions pass so that the loop can settle. It then accumulates the DAC words of a programmable number of further conversions and reports the result. After each report it moves to the next code, until the top transition has been reported.

Software starts a sweep with a one-cycle `start` pulse and supplies the configuration at that point. The configuration is the DAC word to begin at (a little below the first transition), the averaging count, the short or long settling window, and the number of clock cycles the analog DAC needs after each update. The converter side is request/response: the block raises `conv_req` for one cycle, and the next `adc_valid` carries the code. Results leave on a valid/ready stream. While a result is waiting for `res_ready`, the block holds all of its fields and starts no conversion. A slow consumer therefore pauses the sweep without losing anything.

Top module: `adc_edge_servo`

## Requirements
- R1: After reset `dac_word` is 0 and `conv_req`, `res_valid`, `busy` and `done` are all 0.
- R2: A `start` pulse seen while neither `busy` nor running latches the configuration, loads `dac_word` with `cfg_start_word` and makes code 1 the target. A `start` pulse during a sweep, including while a result is held, changes nothing.
- R3: On each accepted conversion, `dac_word` rises by one if `adc_code` is below the target code, and falls by one if `adc_code` is greater than or equal to it.
- R4: `dac_word` never wraps. A step up at all-ones and a step down at zero both leave it unchanged.
- R5: The first step down for a target starts a settling window. With `cfg_long_settle` = 0 the window is 8 conversions, and with `cfg_long_settle` = 1 it is 16. The loop keeps stepping during the window, and words from the window are not accumulated.
- R6: After the window, the DAC words presented during the next M conversions are summed. M is `cfg_avg_count`, and a value of 0 is taken as 1. Stepping continues during these conversions.
- R7: When M is a power of two, `res_value` is the sum shifted right by log2(M) and `res_is_mean` = 1. Otherwise `res_value` is the raw sum and `res_is_mean` = 0. `res_count` always carries M.
- R8: If a conversion before the first downward step finds `dac_word` at all-ones and the code still below the target, that code is reported with `res_error` = 1 and `res_value` = 0. The DAC word is kept and the sweep goes on to the next code.
- R9: `conv_req` lasts one cycle. It is raised no earlier than `cfg_dac_settle`+1 cycles after the edge that last changed `dac_word`. The first `adc_valid` after a request is the only one taken, and `adc_valid` at any other time is ignored.
- R10: `res_valid` with `res_code`, `res_value`, `res_count` and `res_error` stays stable until a cycle with `res_ready` high. No `conv_req` is raised while a result is pending.
- R11: Results come out for codes 1, 2, … up to 2^ADC_BITS−1 in order. After the last result is accepted, `done` = 1 and `busy` = 0 until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep (one-cycle pulse) |
| cfg_long_settle | input | 1 | Settling window: 0 = 8, 1 = 16 conversions |
| cfg_avg_count | input | CNT_W | Number of conversions averaged (M) |
| cfg_dac_settle | input | SETTLE_W | DAC settling time in clock cycles |
| cfg_start_word | input | DAC_BITS | Initial DAC word |
| dac_word | output | DAC_BITS | Word driven to the DAC |
| conv_req | output | 1 | Conversion request pulse |
| adc_valid | input | 1 | Conversion result strobe |
| adc_code | input | ADC_BITS | Conversion result |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_code | output | ADC_BITS | Target code of the result |
| res_value | output | DAC_BITS+CNT_W | Transition level (mean or sum) |
| res_count | output | CNT_W | Number of conversions in the result |
| res_is_mean | output | 1 | 1 when `res_value` is already divided |
| res_error | output | 1 | Transition not found below full scale |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished |

## Verification
Two things can land on the controller at the same time: a held result stalled by a consumer, and converter-side traffic or control that would normally move the loop. The bench provokes this by keeping `res_ready` low for many cycles after the first result. During that stall it pushes a stray `adc_valid` with code 0 and a fresh `start` with a different start word. It then judges that the result fields, `dac_word` and the count of conversion requests are unchanged. It also checks that the later results still land on the transition levels computed from the ideal converter model.

// File: rtl/adc_servo_pkg.sv
package adc_servo_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEEK,
    PH_SETTLE,
    PH_AVERAGE,
    PH_REPORT,
    PH_DONE
  } phase_t;

  typedef enum logic [1:0] {
    PC_WAIT,
    PC_REQ,
    PC_CONV
  } pace_t;

  localparam int unsigned SHORT_WINDOW = 8;
  localparam int unsigned LONG_WINDOW  = 16;

endpackage

// File: rtl/adc_servo_pacer.sv
module adc_servo_pacer
  import adc_servo_pkg::*;
#(
  parameter int SETTLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                adc_valid,
  output logic                conv_req,
  output logic                conv_done
);

  pace_t               state;
  logic [SETTLE_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PC_WAIT;
      wait_cnt <= '0;
    end else if (!enable) begin
      state    <= PC_WAIT;
      wait_cnt <= '0;
    end else begin
      case (state)
        PC_WAIT: begin
          if (wait_cnt == settle_cycles) begin
            state    <= PC_REQ;
            wait_cnt <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        PC_REQ:  state <= PC_CONV;
        PC_CONV: begin
          if (adc_valid) begin
            state    <= PC_WAIT;
            wait_cnt <= '0;
          end
        end
        default: state <= PC_WAIT;
      endcase
    end
  end

  assign conv_req  = enable && (state == PC_REQ);
  assign conv_done = enable && (state == PC_CONV) && adc_valid;

endmodule

// File: rtl/adc_servo_stepper.sv
module adc_servo_stepper #(
  parameter int DAC_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [DAC_BITS-1:0] load_word,
  input  logic                step,
  input  logic                up,
  output logic [DAC_BITS-1:0] dac_word,
  output logic                at_top
);

  logic at_bottom;

  assign at_top    = (dac_word == {DAC_BITS{1'b1}});
  assign at_bottom = (dac_word == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_word <= '0;
    end else if (load) begin
      dac_word <= load_word;
    end else if (step) begin
      if (up && !at_top)
        dac_word <= dac_word + 1'b1;
      else if (!up && !at_bottom)
        dac_word <= dac_word - 1'b1;
    end
  end

endmodule

// File: rtl/adc_servo_accum.sv
module adc_servo_accum #(
  parameter int DAC_BITS = 12,
  parameter int CNT_W    = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        add,
  input  logic [DAC_BITS-1:0]         word,
  input  logic [CNT_W-1:0]            count,
  output logic [DAC_BITS+CNT_W-1:0]   value,
  output logic                        is_mean
);

  localparam int ACC_W = DAC_BITS + CNT_W;

  logic [ACC_W-1:0] sum;
  int unsigned      shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sum <= '0;
    else if (clear)
      sum <= '0;
    else if (add)
      sum <= sum + ACC_W'(word);
  end

  always_comb begin
    shift = 0;
    for (int i = 0; i < CNT_W; i++)
      if (count[i]) shift = i;
  end

  assign is_mean = ($countones(count) == 1);
  assign value   = is_mean ? (sum >> shift) : sum;

endmodule

// File: rtl/adc_edge_servo.sv
module adc_edge_servo
  import adc_servo_pkg::*;
#(
  parameter int ADC_BITS = 8,
  parameter int DAC_BITS = 12,
  parameter int CNT_W    = 12,
  parameter int SETTLE_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        cfg_long_settle,
  input  logic [CNT_W-1:0]            cfg_avg_count,
  input  logic [SETTLE_W-1:0]         cfg_dac_settle,
  input  logic [DAC_BITS-1:0]         cfg_start_word,
  output logic [DAC_BITS-1:0]         dac_word,
  output logic                        conv_req,
  input  logic                        adc_valid,
  input  logic [ADC_BITS-1:0]         adc_code,
  output logic                        res_valid,
  input  logic                        res_ready,
  output logic [ADC_BITS-1:0]         res_code,
  output logic [DAC_BITS+CNT_W-1:0]   res_value,
  output logic [CNT_W-1:0]            res_count,
  output logic                        res_is_mean,
  output logic                        res_error,
  output logic                        busy,
  output logic                        done
);

  localparam logic [ADC_BITS-1:0] LAST_CODE  = {ADC_BITS{1'b1}};
  localparam logic [ADC_BITS-1:0] FIRST_CODE = ADC_BITS'(1);
  localparam logic [4:0] SHORT_LAST = 5'(SHORT_WINDOW - 1);
  localparam logic [4:0] LONG_LAST  = 5'(LONG_WINDOW - 1);

  phase_t              phase;
  logic [ADC_BITS-1:0] target;
  logic [4:0]          window_cnt;
  logic [CNT_W-1:0]    avg_cnt;
  logic                err_flag;
  logic                long_lat;
  logic [CNT_W-1:0]    m_lat;
  logic [SETTLE_W-1:0] dset_lat;

  logic start_go, loop_on, conv_done, below, at_top, accept;
  logic [4:0] window_last;

  assign start_go    = start && ((phase == PH_IDLE) || (phase == PH_DONE));
  assign loop_on     = (phase == PH_SEEK) || (phase == PH_SETTLE) || (phase == PH_AVERAGE);
  assign below       = (adc_code < target);
  assign accept      = (phase == PH_REPORT) && res_ready;
  assign window_last = long_lat ? LONG_LAST : SHORT_LAST;

  adc_servo_pacer #(.SETTLE_W(SETTLE_W)) u_pacer (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (loop_on),
    .settle_cycles(dset_lat),
    .adc_valid    (adc_valid),
    .conv_req     (conv_req),
    .conv_done    (conv_done)
  );

  adc_servo_stepper #(.DAC_BITS(DAC_BITS)) u_stepper (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_go),
    .load_word(cfg_start_word),
    .step     (conv_done),
    .up       (below),
    .dac_word (dac_word),
    .at_top   (at_top)
  );

  adc_servo_accum #(.DAC_BITS(DAC_BITS), .CNT_W(CNT_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_go || accept),
    .add    (conv_done && (phase == PH_AVERAGE)),
    .word   (dac_word),
    .count  (m_lat),
    .value  (res_value),
    .is_mean(res_is_mean)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      target     <= '0;
      window_cnt <= '0;
      avg_cnt    <= '0;
      err_flag   <= 1'b0;
      long_lat   <= 1'b0;
      m_lat      <= CNT_W'(1);
      dset_lat   <= '0;
    end else if (start_go) begin
      phase    <= PH_SEEK;
      target   <= FIRST_CODE;
      err_flag <= 1'b0;
      long_lat <= cfg_long_settle;
      m_lat    <= (cfg_avg_count == '0) ? CNT_W'(1) : cfg_avg_count;
      dset_lat <= cfg_dac_settle;
    end else begin
      case (phase)
        PH_SEEK: begin
          if (conv_done) begin
            if (!below) begin
              phase      <= PH_SETTLE;
              window_cnt <= '0;
            end else if (at_top) begin
              err_flag <= 1'b1;
              phase    <= PH_REPORT;
            end
          end
        end
        PH_SETTLE: begin
          if (conv_done) begin
            if (window_cnt == window_last) begin
              phase   <= PH_AVERAGE;
              avg_cnt <= '0;
            end else begin
              window_cnt <= window_cnt + 1'b1;
            end
          end
        end
        PH_AVERAGE: begin
          if (conv_done) begin
            if (avg_cnt == m_lat - 1'b1)
              phase <= PH_REPORT;
            else
              avg_cnt <= avg_cnt + 1'b1;
          end
        end
        PH_REPORT: begin
          if (res_ready) begin
            err_flag <= 1'b0;
            if (target == LAST_CODE) begin
              phase <= PH_DONE;
            end else begin
              target <= target + 1'b1;
              phase  <= PH_SEEK;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign res_valid = (phase == PH_REPORT);
  assign res_code  = target;
  assign res_count = m_lat;
  assign res_error = err_flag;
  assign busy      = loop_on || (phase == PH_REPORT);
  assign done      = (phase == PH_DONE);

endmodule

// File: rtl/adc_edge_servo_chk.sv
module adc_edge_servo_chk #(
  parameter int ADC_BITS = 8,
  parameter int DAC_BITS = 12,
  parameter int CNT_W    = 12,
  parameter int SETTLE_W = 10
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [SETTLE_W-1:0]       cfg_dac_settle,
  input logic [DAC_BITS-1:0]       dac_word,
  input logic                      conv_req,
  input logic                      res_valid,
  input logic                      res_ready,
  input logic [ADC_BITS-1:0]       res_code,
  input logic [DAC_BITS+CNT_W-1:0] res_value,
  input logic                      res_error,
  input logic                      busy,
  input logic                      done
);

  logic [SETTLE_W:0]   since_move;
  logic [DAC_BITS-1:0] prev_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_move <= '0;
      prev_word  <= '0;
    end else begin
      prev_word <= dac_word;
      if (dac_word != prev_word)
        since_move <= '0;
      else if (since_move != {(SETTLE_W+1){1'b1}})
        since_move <= since_move + 1'b1;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_value) && $stable(res_code) && $stable(res_error)); // R10

  AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !conv_req); // R10

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req); // R9

  AST_REQ_PACING: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> since_move >= {1'b0, cfg_dac_settle}); // R9

  AST_DAC_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (dac_word == $past(dac_word)) || (dac_word == $past(dac_word) + 1'b1)
             || (dac_word + 1'b1 == $past(dac_word))); // R3

  AST_ERROR_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_error |-> dac_word == {DAC_BITS{1'b1}}); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !conv_req && !res_valid && !busy); // R11

  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_code != '0); // R11

endmodule

bind adc_edge_servo adc_edge_servo_chk #(
  .ADC_BITS(ADC_BITS),
  .DAC_BITS(DAC_BITS),
  .CNT_W   (CNT_W),
  .SETTLE_W(SETTLE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_dac_settle(cfg_dac_settle),
  .dac_word      (dac_word),
  .conv_req      (conv_req),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_code      (res_code),
  .res_value     (res_value),
  .res_error     (res_error),
  .busy          (busy),
  .done          (done)
);

// File: tb/adc_edge_servo_test.sv
module adc_edge_servo_test;

  localparam int CLK_PERIOD = 10;
  localparam int AB  = 3;
  localparam int DB  = 6;
  localparam int CW  = 6;
  localparam int SW  = 4;
  localparam int ACC = DB + CW;
  localparam int DSET = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cfg_long_settle = 1'b0;
  logic [CW-1:0] cfg_avg_count = '0;
  logic [SW-1:0] cfg_dac_settle = SW'(DSET);
  logic [DB-1:0] cfg_start_word = '0;
  logic [DB-1:0] dac_word;
  logic          conv_req;
  logic          adc_valid = 1'b0;
  logic [AB-1:0] adc_code = '0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [AB-1:0] res_code;
  logic [ACC-1:0] res_value;
  logic [CW-1:0] res_count;
  logic          res_is_mean, res_error, busy, done;

  int checks = 0;
  int errors = 0;
  int conv_n = 0;
  int model_sel = 0;
  int pace_bad = 0;
  int gap = 0;
  bit stray = 1'b0;
  bit finished = 1'b0;
  int words [0:7];
  logic [DB-1:0] last_dac = '0;

  adc_edge_servo #(.ADC_BITS(AB), .DAC_BITS(DB), .CNT_W(CW), .SETTLE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_long_settle(cfg_long_settle),
    .cfg_avg_count(cfg_avg_count), .cfg_dac_settle(cfg_dac_settle),
    .cfg_start_word(cfg_start_word), .dac_word(dac_word), .conv_req(conv_req),
    .adc_valid(adc_valid), .adc_code(adc_code), .res_valid(res_valid),
    .res_ready(res_ready), .res_code(res_code), .res_value(res_value),
    .res_count(res_count), .res_is_mean(res_is_mean), .res_error(res_error),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AB-1:0] adc_model(input logic [DB-1:0] w);
    int c;
    c = int'(w) / 8;
    if (model_sel == 1 && c > 5) c = 5;
    if (model_sel == 2) c = 7;
    return AB'(c);
  endfunction

  // Converter model: answers one cycle after a request; also injects stray strobes.
  initial begin
    bit pending;
    pending = 1'b0;
    forever begin
      @(negedge clk);
      adc_valid = 1'b0;
      if (dac_word != last_dac) gap = 0; else gap++;
      last_dac = dac_word;
      if (stray) begin
        adc_valid = 1'b1;
        adc_code  = '0;
        stray     = 1'b0;
      end
      if (pending) begin
        adc_valid = 1'b1;
        adc_code  = adc_model(dac_word);
        pending   = 1'b0;
      end
      if (conv_req) begin
        pending = 1'b1;
        if (conv_n < 8) words[conv_n] = int'(dac_word);
        if (gap < DSET + 1) pace_bad++;
        conv_n++;
      end
    end
  end

  task automatic check_val(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input bit lng, input int m, input int sword);
    @(negedge clk);
    cfg_long_settle = lng;
    cfg_avg_count   = CW'(m);
    cfg_start_word  = DB'(sword);
    conv_n = 0;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic wait_result();
    int t;
    t = 0;
    while (!res_valid && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (!res_valid) check_val("R11 result timeout", 0, 1);
  endtask

  task automatic accept();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic expect_res(input string tag, input int code, input int val,
                            input int mean, input int err, input int cnt);
    wait_result();
    check_val({tag, " R11 code"}, res_code, code);
    check_val({tag, " R6 value"}, res_value, val);
    check_val({tag, " R7 mean flag"}, res_is_mean, mean);
    check_val({tag, " R8 error"}, res_error, err);
    check_val({tag, " R7 count"}, res_count, cnt);
    accept();
  endtask

  task automatic expect_finish(input string tag);
    repeat (2) @(negedge clk);
    check_val({tag, " R11 done"}, done, 1);
    check_val({tag, " R11 busy"}, busy, 0);
  endtask

  task automatic t_reset();
    check_val("R1 dac_word", dac_word, 0);
    check_val("R1 conv_req", conv_req, 0);
    check_val("R1 res_valid", res_valid, 0);
    check_val("R1 busy", busy, 0);
    check_val("R1 done", done, 0);
  endtask

  task automatic t_short_window();
    model_sel = 0;
    do_start(1'b0, 4, 5);
    check_val("R2 start word", dac_word, 5);
    check_val("R2 busy", busy, 1);
    wait_result();
    check_val("R5 short window conversions", conv_n, 4 + 8 + 4);
    check_val("R3 step 0", words[0], 5);
    check_val("R3 step 1", words[1], 6);
    check_val("R3 step 3", words[3], 8);
    check_val("R3 step 4", words[4], 7);
    check_val("R3 step 5", words[5], 8);
    for (int k = 1; k <= 7; k++) expect_res("short", k, 8*k - 1, 1, 0, 4);
    expect_finish("short");
  endtask

  task automatic t_long_raw();
    model_sel = 0;
    do_start(1'b1, 3, 5);
    wait_result();
    check_val("R5 long window conversions", conv_n, 4 + 16 + 3);
    for (int k = 1; k <= 7; k++) expect_res("raw", k, 24*k - 2, 0, 0, 3);
    expect_finish("raw");
  endtask

  task automatic t_zero_count();
    model_sel = 0;
    do_start(1'b0, 0, 5);
    wait_result();
    check_val("R6 zero count conversions", conv_n, 4 + 8 + 1);
    for (int k = 1; k <= 7; k++) expect_res("m0", k, 8*k - 1, 1, 0, 1);
    expect_finish("m0");
  endtask

  task automatic t_top_saturate();
    model_sel = 1;
    do_start(1'b0, 4, 5);
    for (int k = 1; k <= 5; k++) expect_res("top", k, 8*k - 1, 1, 0, 4);
    wait_result();
    check_val("R4 R8 dac at full scale code 6", dac_word, 63);
    expect_res("top err", 6, 0, 1, 1, 4);
    wait_result();
    check_val("R4 R8 dac at full scale code 7", dac_word, 63);
    expect_res("top err", 7, 0, 1, 1, 4);
    expect_finish("top");
  endtask

  task automatic t_bottom_saturate();
    model_sel = 2;
    do_start(1'b0, 4, 2);
    for (int k = 1; k <= 7; k++) begin
      wait_result();
      check_val("R4 dac held at zero", dac_word, 0);
      expect_res("bottom", k, 0, 1, 0, 4);
    end
    expect_finish("bottom");
  endtask

  task automatic t_stall();
    int n0;
    logic [DB-1:0] w0;
    model_sel = 0;
    do_start(1'b0, 4, 5);
    wait_result();
    n0 = conv_n;
    w0 = dac_word;
    for (int i = 0; i < 20; i++) begin
      if (i == 5) stray = 1'b1;
      if (i == 10) begin
        cfg_start_word = DB'(40);
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check_val("R10 valid held", res_valid, 1);
    check_val("R10 value held", res_value, 7);
    check_val("R10 code held", res_code, 1);
    check_val("R10 no conversions while held", conv_n, n0);
    check_val("R9 stray strobe ignored", dac_word, w0);
    check_val("R2 start ignored while busy", busy, 1);
    accept();
    for (int k = 2; k <= 7; k++) expect_res("stall", k, 8*k - 1, 1, 0, 4);
    expect_finish("stall");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_short_window();
    t_long_raw();
    t_zero_count();
    t_top_saturate();
    t_bottom_saturate();
    t_stall();
    check_val("R9 request pacing violations", pace_bad, 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule